// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block sits on the host side of an eight-channel, 14-bit voltage-output DAC that has a double-buffered parallel bus. Write requests arrive on a valid/ready handshake. Each request carries a channel number, a signed two's-complement sample and an update flag. The block turns each accepted request into a timed sequence on the DAC pins. It first presents the address and data. It then pulls chip-select and write low together, releases them, and holds the address and data afterwards. When the update flag is set, it adds a load pulse that moves every pending input register into its output register at the same moment.

All timing comes from nanosecond minimums and the clock period, both given as parameters. The block rounds each minimum up to whole clock cycles. The load pulse falls only after the input latch has closed and a minimum gap has passed, which keeps glitches from the DAC ladder off the outputs. Several channels can be written with the update flag clear and then released together by one request with the flag set. A separate clear request drives the DAC clear pin low for a fixed number of cycles. A clear never overlaps a write sequence.

Top module: `dacseq_bus_writer`

## Requirements
- R1: After reset, `dac_cs_no`, `dac_wr_no`, `dac_ld_no` and `dac_clr_no` are high, `req_ready_o` is high, and `dac_addr_o` and `dac_data_o` are zero.
- R2: The code driven on `dac_data_o` is the offset-binary form of the sample: the sample plus 8192, modulo 2^14, which is the sample with bit 13 inverted (-8192 gives 0x0000, 0 gives 0x2000, 8191 gives 0x3FFF).
- R3: For each request, `dac_cs_no` and `dac_wr_no` go low in the same cycle and stay low together for STRB cycles. STRB is the larger of the 50 ns minimum low time and the 20 ns data setup, each rounded up to whole clocks, so STRB is 5 at 100 MHz. Address and data are driven one cycle before the strobes fall.
- R4: `dac_addr_o` and `dac_data_o` do not change while chip-select is low, nor for HOLD cycles after it rises. HOLD is 15 ns rounded up, which is 2 at 100 MHz.
- R5: `dac_addr_o` carries the requested channel number (0 to 7) unchanged.
- R6: A request with `req_update_i` clear produces no load pulse.
- R7: A request with `req_update_i` set produces exactly one `dac_ld_no` low pulse of 5 cycles at 100 MHz (50 ns). The pulse falls no earlier than 5 cycles after chip-select rises (50 ns gap). Load is never low while write or chip-select is low.
- R8: Several requests with the update flag clear, followed by one with it set, produce exactly one load pulse in total.
- R9: `req_ready_o` is low from the cycle after acceptance until the sequence is back in idle, and it is never high while any DAC strobe is low. At 100 MHz, ready returns 8 cycles after acceptance without a load and 16 cycles after acceptance with one.
- R10: A one-cycle pulse on `clr_req_i` is held pending and drives `dac_clr_no` low for CLR_LOW_CYC cycles (4 by default) once the sequencer is idle. The pending clear runs before any new write is accepted. Clear is never low while chip-select or load is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Sequencer idle and able to accept |
| req_chan_i | input | 3 | Target channel |
| req_sample_i | input | 14 | Signed two's-complement sample |
| req_update_i | input | 1 | Issue a simultaneous load after this write |
| clr_req_i | input | 1 | Clear request pulse |
| dac_cs_no | output | 1 | DAC chip-select, active low |
| dac_wr_no | output | 1 | DAC write strobe, active low |
| dac_ld_no | output | 1 | DAC load strobe, active low |
| dac_clr_no | output | 1 | DAC clear, active low |
| dac_addr_o | output | 3 | DAC channel address |
| dac_data_o | output | 14 | Offset-binary DAC code |

## Verification
The hardest case to reach from the ports is a clear request that arrives in the middle of a write with a load, while a second write is already waiting on ready. The clear must wait for the load pulse to finish and must then run before the waiting write reaches the bus. The bench reaches this case by forking the clear pulse into the cycles when chip-select is low, while another task waits on ready with a new request. It then checks that the clear count recorded at the second chip-select fall is one higher than before. Batched writes and samples at the ends of the signed range cover the conversion and the single-load rule.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_HOLD,
    ST_LOAD,
    ST_CLR
  } phase_e;

  // round a nanosecond minimum up to whole clocks, at least one
  function automatic int ns_to_cyc(input int t_ns, input int period_ps);
    int c;
    c = (t_ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacseq_code_conv.sv
module dacseq_code_conv #(
  parameter int DATA_W    = 14,
  parameter bit SIGNED_IN = 1'b1
) (
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] code_o
);

  generate
    if (SIGNED_IN) begin : g_twos
      // adding half scale only flips the sign bit
      assign code_o = {~sample_i[DATA_W-1], sample_i[DATA_W-2:0]};
    end else begin : g_pass
      assign code_o = sample_i;
    end
  endgenerate

endmodule

// File: rtl/dacseq_phase_timer.sv
module dacseq_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3: every phase lasts at least one cycle
  a_r3_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));

endmodule

// File: rtl/dacseq_ctrl.sv
module dacseq_ctrl
  import dacseq_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int ASU_CYC     = 1,
  parameter int STRB_CYC    = 5,
  parameter int HOLD_CYC    = 2,
  parameter int HOLD_LD_CYC = 5,
  parameter int LD_CYC      = 5,
  parameter int CLR_CYC     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_update_i,
  input  logic clr_req_i,
  output logic ready_o,
  output logic accept_o,
  output logic cs_no,
  output logic wr_no,
  output logic ld_no,
  output logic clr_no
);

  phase_e           state_q, state_d;
  logic             upd_q, clr_pend_q;
  logic             tmr_done, tmr_load;
  logic [CNT_W-1:0] dur;
  logic             enter_clr;

  assign ready_o  = (state_q == ST_IDLE) && !clr_pend_q;
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    state_d = state_q;
    dur     = CNT_W'(1);
    unique case (state_q)
      ST_IDLE: begin
        if (clr_pend_q) begin
          state_d = ST_CLR;
          dur     = CNT_W'(CLR_CYC);
        end else if (accept_o) begin
          state_d = ST_SETUP;
          dur     = CNT_W'(ASU_CYC);
        end
      end
      ST_SETUP: if (tmr_done) begin
        state_d = ST_STRB;
        dur     = CNT_W'(STRB_CYC);
      end
      ST_STRB: if (tmr_done) begin
        state_d = ST_HOLD;
        // load gap is folded into the hold phase
        dur     = upd_q ? CNT_W'(HOLD_LD_CYC) : CNT_W'(HOLD_CYC);
      end
      ST_HOLD: if (tmr_done) begin
        if (upd_q) begin
          state_d = ST_LOAD;
          dur     = CNT_W'(LD_CYC);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_LOAD: if (tmr_done) state_d = ST_IDLE;
      ST_CLR:  if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_load  = (state_d != state_q);
  assign enter_clr = (state_q == ST_IDLE) && (state_d == ST_CLR);

  dacseq_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (dur),
    .done_o (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      upd_q      <= 1'b0;
      clr_pend_q <= 1'b0;
      cs_no      <= 1'b1;
      wr_no      <= 1'b1;
      ld_no      <= 1'b1;
      clr_no     <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept_o) upd_q <= req_update_i;
      if (enter_clr)      clr_pend_q <= 1'b0;
      else if (clr_req_i) clr_pend_q <= 1'b1;
      // strobes registered from next phase: glitch-free pins
      cs_no  <= (state_d != ST_STRB);
      wr_no  <= (state_d != ST_STRB);
      ld_no  <= (state_d != ST_LOAD);
      clr_no <= (state_d != ST_CLR);
    end
  end

  // R10: a pending clear blocks acceptance
  a_r10_clr_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pend_q |-> !accept_o);

  // R9: ready low while any sequence phase runs
  a_r9_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !ready_o);

endmodule

// File: rtl/dacseq_bus_writer.sv
module dacseq_bus_writer
  import dacseq_pkg::*;
#(
  parameter int NUM_CH         = 8,
  parameter int DATA_W         = 14,
  parameter int CLK_PERIOD_PS  = 10000,
  parameter int T_LOW_NS       = 50,
  parameter int T_DSU_NS       = 20,
  parameter int T_DH_NS        = 15,
  parameter int T_LDGAP_NS     = 50,
  parameter int ADDR_SETUP_CYC = 1,
  parameter int CLR_LOW_CYC    = 4,
  localparam int CH_W          = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CH_W-1:0]   req_chan_i,
  input  logic [DATA_W-1:0] req_sample_i,
  input  logic              req_update_i,
  input  logic              clr_req_i,
  output logic              dac_cs_no,
  output logic              dac_wr_no,
  output logic              dac_ld_no,
  output logic              dac_clr_no,
  output logic [CH_W-1:0]   dac_addr_o,
  output logic [DATA_W-1:0] dac_data_o
);

  localparam int STRB_CYC    = imax(ns_to_cyc(T_LOW_NS, CLK_PERIOD_PS),
                                    ns_to_cyc(T_DSU_NS, CLK_PERIOD_PS));
  localparam int HOLD_CYC    = ns_to_cyc(T_DH_NS, CLK_PERIOD_PS);
  localparam int GAP_CYC     = ns_to_cyc(T_LDGAP_NS, CLK_PERIOD_PS);
  localparam int HOLD_LD_CYC = imax(HOLD_CYC, GAP_CYC);
  localparam int LD_CYC      = ns_to_cyc(T_LOW_NS, CLK_PERIOD_PS);
  localparam int MAX_CYC     = imax(imax(STRB_CYC, HOLD_LD_CYC),
                                    imax(LD_CYC, imax(CLR_LOW_CYC, ADDR_SETUP_CYC)));
  localparam int CNT_W       = $clog2(MAX_CYC + 1) + 1;

  logic              accept;
  logic [DATA_W-1:0] code;
  logic [CH_W-1:0]   addr_q;
  logic [DATA_W-1:0] data_q;

  dacseq_code_conv #(.DATA_W(DATA_W), .SIGNED_IN(1'b1)) u_conv (
    .sample_i (req_sample_i),
    .code_o   (code)
  );

  dacseq_ctrl #(
    .CNT_W       (CNT_W),
    .ASU_CYC     (ADDR_SETUP_CYC),
    .STRB_CYC    (STRB_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .HOLD_LD_CYC (HOLD_LD_CYC),
    .LD_CYC      (LD_CYC),
    .CLR_CYC     (CLR_LOW_CYC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_update_i (req_update_i),
    .clr_req_i    (clr_req_i),
    .ready_o      (req_ready_o),
    .accept_o     (accept),
    .cs_no        (dac_cs_no),
    .wr_no        (dac_wr_no),
    .ld_no        (dac_ld_no),
    .clr_no       (dac_clr_no)
  );

  // address and data launch at acceptance, ahead of the strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_chan_i;
      data_q <= code;
    end
  end

  assign dac_addr_o = addr_q;
  assign dac_data_o = data_q;

  // checker counters: cycles of chip-select low, cycles since its release
  logic [CNT_W-1:0] cs_low_cnt, since_rise;
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_low_cnt <= '0;
      since_rise <= SAT;
    end else begin
      if (dac_cs_no)             cs_low_cnt <= '0;
      else if (cs_low_cnt != SAT) cs_low_cnt <= cs_low_cnt + 1'b1;
      if (!dac_cs_no)            since_rise <= '0;
      else if (since_rise != SAT) since_rise <= since_rise + 1'b1;
    end
  end

  a_r3_strobe_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_cs_no) |-> (cs_low_cnt >= CNT_W'(STRB_CYC)));

  a_r4_stable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_cs_no && $past(!dac_cs_no)) |-> ($stable(dac_addr_o) && $stable(dac_data_o)));

  a_r4_stable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_cs_no && since_rise < CNT_W'(HOLD_CYC)) |-> ($stable(dac_addr_o) && $stable(dac_data_o)));

  a_r7_load_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_ld_no) |-> (since_rise >= CNT_W'(GAP_CYC)));

  a_r7_load_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_ld_no |-> (dac_wr_no && dac_cs_no));

  a_r9_ready_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_cs_no || !dac_ld_no || !dac_clr_no) |-> !req_ready_o);

  a_r10_clr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_clr_no |-> (dac_cs_no && dac_ld_no));

endmodule

// File: tb/dacseq_bus_writer_tb.sv
module dacseq_bus_writer_tb;

  localparam int STRB = 5;
  localparam int HOLD = 2;
  localparam int GAP  = 5;
  localparam int LDW  = 5;
  localparam int CLRW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  req_chan_i = '0;
  logic [13:0] req_sample_i = '0;
  logic        req_update_i = 1'b0;
  logic        clr_req_i = 1'b0;
  logic        dac_cs_no, dac_wr_no, dac_ld_no, dac_clr_no;
  logic [2:0]  dac_addr_o;
  logic [13:0] dac_data_o;

  always #5 clk_i = ~clk_i;

  dacseq_bus_writer u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_chan_i   (req_chan_i),
    .req_sample_i (req_sample_i),
    .req_update_i (req_update_i),
    .clr_req_i    (clr_req_i),
    .dac_cs_no    (dac_cs_no),
    .dac_wr_no    (dac_wr_no),
    .dac_ld_no    (dac_ld_no),
    .dac_clr_no   (dac_clr_no),
    .dac_addr_o   (dac_addr_o),
    .dac_data_o   (dac_data_o)
  );

  typedef struct packed {
    logic [2:0]  chan;
    logic [13:0] code;
    logic        upd;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor state
  logic        prev_cs = 1'b1, prev_ld = 1'b1, prev_clr = 1'b1;
  logic [2:0]  cap_addr;
  logic [13:0] cap_data;
  int cs_low_n, wr_low_n, stab_bad, hold_left, since_rise = 100;
  int ld_low_n, clr_low_n, ld_pulses = 0, clr_seen = 0, cs_fall_clr = 0;
  int rdy_bad = 0, excl_bad = 0;
  bit ld_due = 1'b0;

  always @(negedge clk_i) if (rst_ni) begin
    if (req_ready_o && (!dac_cs_no || !dac_wr_no || !dac_ld_no || !dac_clr_no))
      rdy_bad++;
    if (!dac_clr_no && (!dac_cs_no || !dac_ld_no)) excl_bad++;

    if (!dac_cs_no) begin
      if (prev_cs) begin
        cap_addr = dac_addr_o; cap_data = dac_data_o;
        cs_low_n = 0; wr_low_n = 0; stab_bad = 0; cs_fall_clr = clr_seen;
      end
      cs_low_n++;
      if (!dac_wr_no) wr_low_n++;
      if (dac_addr_o != cap_addr || dac_data_o != cap_data) stab_bad++;
    end else if (!prev_cs) begin
      exp_t e;
      since_rise = 0;
      hold_left = HOLD;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "strobe without request", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(dac_addr_o == e.chan, "R5", "address", int'(dac_addr_o), int'(e.chan));
        chk(dac_data_o == e.code, "R2", "offset-binary code", int'(dac_data_o), int'(e.code));
        chk(cs_low_n == STRB, "R3", "chip-select low cycles", cs_low_n, STRB);
        chk(wr_low_n == STRB, "R3", "write low cycles with chip-select", wr_low_n, STRB);
        if (e.upd) ld_due = 1'b1;
      end
    end else begin
      since_rise++;
    end

    if (dac_cs_no && hold_left > 0) begin
      if (dac_addr_o != cap_addr || dac_data_o != cap_data) stab_bad++;
      hold_left--;
      if (hold_left == 0) chk(stab_bad == 0, "R4", "address/data changes", stab_bad, 0);
    end

    if (!dac_ld_no && prev_ld) begin
      chk(ld_due, "R6", "load pulse without update flag", 1, int'(ld_due));
      chk(since_rise >= GAP, "R7", "load gap after chip-select", since_rise, GAP);
      ld_due = 1'b0;
      ld_low_n = 0;
    end
    if (!dac_ld_no) ld_low_n++;
    if (dac_ld_no && !prev_ld) begin
      chk(ld_low_n == LDW, "R7", "load low cycles", ld_low_n, LDW);
      ld_pulses++;
    end

    if (!dac_clr_no && prev_clr) clr_low_n = 0;
    if (!dac_clr_no) clr_low_n++;
    if (dac_clr_no && !prev_clr) begin
      chk(clr_low_n == CLRW, "R10", "clear low cycles", clr_low_n, CLRW);
      clr_seen++;
    end

    prev_cs = dac_cs_no; prev_ld = dac_ld_no; prev_clr = dac_clr_no;
  end

  // driver: returns cycles from acceptance until ready is high again
  task automatic write_req(input logic [2:0] ch, input logic [13:0] s,
                           input logic upd, output int lat);
    exp_t e;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_chan_i = ch; req_sample_i = s; req_update_i = upd;
    @(posedge clk_i);
    e.chan = ch; e.code = s + 14'd8192; e.upd = upd;
    exp_q.push_back(e);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 0;
    while (!req_ready_o) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk_i);
    clr_req_i = 1'b1;
    @(negedge clk_i);
    clr_req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int lat, ld0, clr0;
    logic [13:0] samples [8];
    samples[0] = 14'h2000; samples[1] = 14'h1FFF; samples[2] = 14'h3FFF; samples[3] = 14'h0000;
    samples[4] = 14'h0001; samples[5] = 14'h2001; samples[6] = 14'h13B2; samples[7] = 14'h2C4E;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk({dac_cs_no, dac_wr_no, dac_ld_no, dac_clr_no} == 4'hF, "R1", "strobes after reset",
        int'({dac_cs_no, dac_wr_no, dac_ld_no, dac_clr_no}), 15);
    chk(req_ready_o == 1'b1, "R1", "ready after reset", int'(req_ready_o), 1);
    chk(dac_addr_o == 3'd0 && dac_data_o == 14'd0, "R1", "addr/data after reset",
        int'(dac_data_o), 0);

    // R9/R6 single write without load
    ld0 = ld_pulses;
    write_req(3'd3, 14'h0000, 1'b0, lat);
    chk(lat == 8, "R9", "ready latency without load", lat, 8);
    idle(3);
    chk(ld_pulses == ld0, "R6", "load pulses without update", ld_pulses - ld0, 0);

    // R2/R5 every channel, varied samples
    for (int i = 0; i < 8; i++) write_req(3'(i), samples[i], 1'b0, lat);
    idle(3);
    chk(ld_pulses == ld0, "R6", "load pulses after plain writes", ld_pulses - ld0, 0);

    // R7/R9 write with load
    ld0 = ld_pulses;
    write_req(3'd6, 14'h3FFF, 1'b1, lat);
    chk(lat == 16, "R9", "ready latency with load", lat, 16);
    idle(2);
    chk(ld_pulses == ld0 + 1, "R7", "load pulses with update", ld_pulses - ld0, 1);

    // R8 batch then one load
    ld0 = ld_pulses;
    write_req(3'd1, 14'h0123, 1'b0, lat);
    write_req(3'd2, 14'h2345, 1'b0, lat);
    write_req(3'd5, 14'h3E00, 1'b0, lat);
    write_req(3'd7, 14'h1000, 1'b1, lat);
    idle(2);
    chk(ld_pulses == ld0 + 1, "R8", "load pulses for batch", ld_pulses - ld0, 1);

    // R10 clear from idle
    clr0 = clr_seen;
    pulse_clr();
    idle(8);
    chk(clr_seen == clr0 + 1, "R10", "clear pulses from idle", clr_seen - clr0, 1);
    chk(req_ready_o, "R10", "ready after clear", int'(req_ready_o), 1);

    // R10 clear during a write with load, next write waiting
    clr0 = clr_seen;
    fork
      write_req(3'd4, 14'h0FFF, 1'b1, lat);
      begin
        @(negedge clk_i);
        while (dac_cs_no) @(negedge clk_i);
        pulse_clr();
      end
    join
    write_req(3'd0, 14'h2ABC, 1'b0, lat);
    idle(3);
    chk(cs_fall_clr == clr0 + 1, "R10", "clear ran before waiting write", cs_fall_clr - clr0, 1);
    chk(clr_seen == clr0 + 1, "R10", "clear pulses during write", clr_seen - clr0, 1);

    idle(5);
    chk(exp_q.size() == 0, "R5", "requests never strobed", exp_q.size(), 0);
    chk(!ld_due, "R7", "load owed but not issued", int'(ld_due), 0);
    chk(rdy_bad == 0, "R9", "ready high during strobes", rdy_bad, 0);
    chk(excl_bad == 0, "R10", "clear overlapping strobes", excl_bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule